// File: doc/BRIEF.md
# Nested-scale 4-bit weight dequantizer

This block takes super-blocks of packed 4-bit quantized weights and turns them into signed integer weights, each multiplied by its own sub-block scale. A super-block holds 128 weights in 16 sub-blocks of 8. Each sub-block has a signed 8-bit scale, and the whole super-block shares one 16-bit half-precision scale. The block does not interpret the half-precision scale. It passes that scale along unchanged on every output beat, so that a later floating-point stage can apply it. Weight codes are stored offset-binary: the unit subtracts 8 from each code, which gives a value in -8..+7.

Input arrives as 32-bit words over a valid/ready handshake, 21 words per super-block, in this order:
- the super-scale word;
- four scale words;
- sixteen nibble words, one per sub-block.

Each nibble word yields one output beat of eight 16-bit weights. The beat is tagged with its sub-block index and carries a last flag. The output beat sits in a register, so backpressure stalls the beat without losing data. A new nibble word is taken in the same cycle that the held beat leaves. The header of the next super-block can be taken in while the final beat of the previous one is still waiting.

Top module: `nibble_dequant`

## Requirements
- R1: After rst_ni is asserted (active-low, asynchronous), out_valid_o is 0 and in_ready_o is 1. The unit then waits for word 0 of a new super-block, even if it was in the middle of one.
- R2: Word 0 of a super-block carries the super-scale in bits [15:0]; bits [31:16] are ignored. Every beat of that super-block shows the super-scale unchanged on out_dscale_o.
- R3: Words 1 to 4 carry the signed sub-block scales. Scale n sits in byte (n mod 4) of word 1 + n/4, where byte 0 is bits [7:0].
- R4: Words 5 to 20 are nibble words, and word 5 + n belongs to sub-block n. Each nibble word produces exactly one beat. Beats of a super-block come out with out_sub_o = 0, 1, …, 15 in that order.
- R5: Output lane k uses code bits [4k+3:4k] of the nibble word. So lane 2j takes the low nibble of byte j and lane 2j+1 takes the high nibble of byte j.
- R6: Lane k equals scale × (code − 8), sign-extended to 16 bits and placed on out_w_o bits [16k+15:16k]. The scale is treated as signed two's complement and the code as unsigned 0..15.
- R7: out_last_o is 1 on the beat with out_sub_o = 15 and 0 on every other beat.
- R8: While out_valid_o is 1 and out_ready_i is 0, every output holds steady. During the nibble phase in_ready_o is 0 at those times, and no beat is lost or duplicated.
- R9: When a held beat is taken in the same cycle that the next nibble word is offered, the word is accepted in that cycle and its beat is valid in the next cycle, with no bubble between them.
- R10: The header words of the next super-block are accepted while the final beat of the previous super-block is still stalled. That beat keeps its own super-scale and last flag.
- R11: The beat for a nibble word is valid in the cycle after that word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 32 | Input word |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Unit can accept a word |
| out_w_o | output | 128 | Eight 16-bit signed weights, lane k at bits [16k+15:16k] |
| out_sub_o | output | 4 | Sub-block index of the beat |
| out_dscale_o | output | 16 | Super-scale passed through unchanged |
| out_last_o | output | 1 | Beat is sub-block 15 |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream takes the beat |

## Verification
Two events can fall on the same clock edge: the output register releases a beat, and the ingest side loads a new nibble word. The stall test holds out_ready_i low with the next nibble word already offered, and confirms that the beat and in_ready_o stay frozen. It then raises out_ready_i and requires sub-block n+1 on the very next cycle. A second overlap happens when the final beat is stalled while the next super-block's header streams in. That case is judged by checking that the pending beat still shows the old super-scale and last flag, and that the new super-block's beats decode correctly afterwards.

// File: rtl/nibble_dequant_pkg.sv
package nibble_dequant_pkg;
  typedef enum logic [1:0] {
    PH_DSCALE = 2'd0,
    PH_SCALE  = 2'd1,
    PH_NIB    = 2'd2
  } phase_e;
endpackage

// File: rtl/dq_lane.sv
module dq_lane #(
  parameter int CODE_W = 4,
  parameter int SC_W   = 8,
  parameter int W_W    = 16
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [SC_W-1:0]   scale_i,
  output logic [W_W-1:0]    w_o
);
  localparam int CEN_W  = CODE_W + 1;
  localparam int PROD_W = SC_W + CODE_W;
  localparam logic signed [CEN_W-1:0] BIAS = CEN_W'(1 << (CODE_W - 1));

  logic signed [CEN_W-1:0]  cen;
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    cen  = $signed({1'b0, code_i}) - BIAS;
    prod = $signed(scale_i) * cen;
    w_o  = {{(W_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  // |scale*code| bounded by 2^(SC_W-1) * 2^(CODE_W-1)
  always_comb begin
    AST_LANE_RANGE: assert (cen >= -BIAS && cen < BIAS); // R6
  end
endmodule

// File: rtl/dq_ingest.sv
module dq_ingest
  import nibble_dequant_pkg::*;
#(
  parameter int DW   = 32,
  parameter int SUBS = 16,
  parameter int SC_W = 8,
  parameter int DS_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DW-1:0]           in_data_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic                    out_free_i,
  output logic                    nib_fire_o,
  output logic [$clog2(SUBS)-1:0] sub_o,
  output logic [SC_W-1:0]         scale_o,
  output logic [DS_W-1:0]         dscale_o
);
  localparam int CW       = $clog2(SUBS);
  localparam int SC_WORDS = SUBS * SC_W / DW;

  phase_e                 phase_q;
  logic [CW-1:0]          cnt_q;
  logic [SUBS*SC_W-1:0]   sc_q;
  logic [DS_W-1:0]        ds_q;
  logic                   fire;

  always_comb begin
    in_ready_o = (phase_q == PH_NIB) ? out_free_i : 1'b1;
    fire       = in_valid_i && in_ready_o;
    nib_fire_o = fire && (phase_q == PH_NIB);
    sub_o      = cnt_q;
    scale_o    = sc_q[int'(cnt_q)*SC_W +: SC_W];
    dscale_o   = ds_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DSCALE;
      cnt_q   <= '0;
      sc_q    <= '0;
      ds_q    <= '0;
    end else if (fire) begin
      unique case (phase_q)
        PH_DSCALE: begin
          ds_q    <= in_data_i[DS_W-1:0];
          cnt_q   <= '0;
          phase_q <= PH_SCALE;
        end
        PH_SCALE: begin
          sc_q[int'(cnt_q)*DW +: DW] <= in_data_i;
          if (cnt_q == CW'(SC_WORDS - 1)) begin
            cnt_q   <= '0;
            phase_q <= PH_NIB;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == CW'(SUBS - 1)) begin
            cnt_q   <= '0;
            phase_q <= PH_DSCALE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  AST_HDR_ALWAYS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_NIB) |-> in_ready_o); // R10
  AST_SCALE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_NIB) |=> $stable(sc_q) && $stable(ds_q)); // R3
endmodule

// File: rtl/nibble_dequant.sv
module nibble_dequant #(
  parameter int DW     = 32,
  parameter int SUBS   = 16,
  parameter int LANES  = 8,
  parameter int CODE_W = 4,
  parameter int SC_W   = 8,
  parameter int DS_W   = 16,
  parameter int W_W    = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DW-1:0]           in_data_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  output logic [LANES*W_W-1:0]    out_w_o,
  output logic [$clog2(SUBS)-1:0] out_sub_o,
  output logic [DS_W-1:0]         out_dscale_o,
  output logic                    out_last_o,
  output logic                    out_valid_o,
  input  logic                    out_ready_i
);
  localparam int CW = $clog2(SUBS);

  logic                   out_free;
  logic                   nib_fire;
  logic [CW-1:0]          sub;
  logic [SC_W-1:0]        scale;
  logic [DS_W-1:0]        dscale;
  logic [LANES*W_W-1:0]   lane_w;

  assign out_free = !out_valid_o || out_ready_i;

  dq_ingest #(.DW(DW), .SUBS(SUBS), .SC_W(SC_W), .DS_W(DS_W)) u_ingest (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_data_i  (in_data_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .out_free_i (out_free),
    .nib_fire_o (nib_fire),
    .sub_o      (sub),
    .scale_o    (scale),
    .dscale_o   (dscale)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dq_lane #(.CODE_W(CODE_W), .SC_W(SC_W), .W_W(W_W)) u_lane (
      .code_i  (in_data_i[k*CODE_W +: CODE_W]),
      .scale_i (scale),
      .w_o     (lane_w[k*W_W +: W_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_w_o      <= '0;
      out_sub_o    <= '0;
      out_dscale_o <= '0;
      out_last_o   <= 1'b0;
    end else if (nib_fire) begin
      out_valid_o  <= 1'b1;
      out_w_o      <= lane_w;
      out_sub_o    <= sub;
      out_dscale_o <= dscale;
      out_last_o   <= (sub == CW'(SUBS - 1));
    end else if (out_ready_i) begin
      out_valid_o  <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_w_o)
      && $stable(out_sub_o) && $stable(out_dscale_o) && $stable(out_last_o)); // R8
  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !nib_fire); // R8
  AST_LOAD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_fire |=> out_valid_o); // R11
  AST_LAST_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_last_o == (out_sub_o == CW'(SUBS - 1)))); // R7
endmodule

// File: tb/nibble_dequant_test.sv
module nibble_dequant_test;
  localparam int CLK_PERIOD = 10;
  localparam int SUBS = 16;
  localparam int LANES = 8;

  logic         clk = 0;
  logic         rst_ni = 0;
  logic [31:0]  in_data = '0;
  logic         in_valid = 0;
  logic         in_ready;
  logic [127:0] out_w;
  logic [3:0]   out_sub;
  logic [15:0]  out_dscale;
  logic         out_last;
  logic         out_valid;
  logic         out_ready = 0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  logic [15:0] exp_ds [2];
  logic [7:0]  exp_sc [2][SUBS];
  logic [31:0] exp_nib[2][SUBS];
  int tx_slot = 0;
  int rx_slot = 0;
  int rx_n = 0;
  int total_beats = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_dequant uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .out_w_o(out_w), .out_sub_o(out_sub),
    .out_dscale_o(out_dscale), .out_last_o(out_last), .out_valid_o(out_valid),
    .out_ready_i(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen_sc(int s, int n);
    if (s == 0 && n == 0) return 8'h80;
    if (s == 0 && n == 1) return 8'h7F;
    if (s == 0 && n == 2) return 8'h00;
    if (s == 0 && n == 3) return 8'hFF;
    return 8'((n * 37 + s * 11 + 5) & 255);
  endfunction

  function automatic logic [31:0] gen_nib(int s, int n);
    if (s == 0 && n == 0) return 32'h0000_0000;
    if (s == 0 && n == 1) return 32'hFFFF_FFFF;
    if (s == 0 && n == 2) return 32'h7654_3210;
    if (s == 0 && n == 3) return 32'hFEDC_BA98;
    return 32'(n * 32'h9E37_79B9) ^ 32'(s * 32'h85EB_CA6B);
  endfunction

  // Monitor: judges each beat taken by downstream
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_ni && out_valid && out_ready) begin
        logic [15:0] ew, aw;
        bit ok_w;
        ok_w = 1; ew = '0; aw = '0;
        for (int k = 0; k < LANES; k++) begin
          logic [3:0] code;
          logic signed [15:0] e;
          code = exp_nib[rx_slot][rx_n][4*k +: 4];
          e = 16'($signed(exp_sc[rx_slot][rx_n]) * ($signed({1'b0, code}) - 16'sd8));
          if (ok_w && out_w[16*k +: 16] !== e) begin
            ok_w = 0; ew = e; aw = out_w[16*k +: 16];
          end
        end
        chk(ok_w, "R5/R6 lane weight", 32'(aw), 32'(ew));
        chk(out_sub == 4'(rx_n), "R4 sub index", 32'(out_sub), 32'(rx_n));
        chk(out_dscale == exp_ds[rx_slot], "R2 super-scale", 32'(out_dscale), 32'(exp_ds[rx_slot]));
        chk(out_last == (rx_n == SUBS-1), "R7 last flag", 32'(out_last), 32'(rx_n == SUBS-1));
        total_beats++;
        if (rx_n == SUBS-1) begin rx_n = 0; rx_slot ^= 1; end
        else rx_n++;
      end
    end
  end

  task automatic send(input logic [31:0] d);
    in_data = d; in_valid = 1; #1;
    while (!in_ready) begin @(negedge clk); out_ready = 1; #1; end
    @(posedge clk); @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_hdr(input int s);
    exp_ds[tx_slot] = 16'h3C00 + 16'(s);
    for (int n = 0; n < SUBS; n++) begin
      exp_sc[tx_slot][n]  = gen_sc(s, n);
      exp_nib[tx_slot][n] = gen_nib(s, n);
    end
    send({16'hA5A5 ^ 16'(s), exp_ds[tx_slot]}); // R2 upper half junk
    for (int w = 0; w < 4; w++)
      send({exp_sc[tx_slot][4*w+3], exp_sc[tx_slot][4*w+2], exp_sc[tx_slot][4*w+1], exp_sc[tx_slot][4*w]}); // R3
  endtask

  task automatic send_nibs(input int from, input int mode);
    for (int n = from; n < SUBS; n++) begin
      if (mode == 1) out_ready = (n % 3 != 0);
      send(exp_nib[tx_slot][n]);
    end
    tx_slot ^= 1;
  endtask

  task automatic drain;
    out_ready = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk(out_valid == 0, "R1 reset valid", 32'(out_valid), 0);
    chk(in_ready == 1, "R1 reset ready", 32'(in_ready), 1);
  endtask

  task automatic t_basic;
    out_ready = 1;
    send_hdr(0);
    send(exp_nib[tx_slot][0]);
    chk(out_valid && out_sub == 0, "R11 latency", 32'({out_valid, out_sub}), 32'h10);
    send_nibs(1, 0);
    drain;
  endtask

  task automatic t_stall;
    logic [127:0] w0;
    out_ready = 0;
    send_hdr(1);
    send(exp_nib[tx_slot][0]);
    w0 = out_w;
    in_data = exp_nib[tx_slot][1]; in_valid = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 0, "R8 ready low while held", 32'(in_ready), 0);
    chk(out_valid && out_sub == 0 && out_w == w0, "R8 beat held", 32'(out_sub), 0);
    out_ready = 1; #1;
    chk(in_ready == 1, "R9 accept during drain", 32'(in_ready), 1);
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk(out_valid && out_sub == 1, "R9 no bubble", 32'({out_valid, out_sub}), 32'h11);
    send_nibs(2, 1);
    drain;
  endtask

  task automatic t_overlap;
    out_ready = 1;
    send_hdr(2);
    send_nibs(0, 0);
    out_ready = 0;
    send_hdr(3);
    #1;
    chk(out_valid && out_last, "R10 last beat still held", 32'({out_valid, out_last}), 32'h3);
    chk(out_dscale == 16'h3C02, "R10 old super-scale kept", 32'(out_dscale), 32'h3C02);
    out_ready = 1;
    send_nibs(0, 0);
    drain;
  endtask

  task automatic t_mid_reset;
    out_ready = 0;
    send_hdr(4);
    send(exp_nib[tx_slot][0]);
    @(negedge clk);
    rst_ni = 0; #1;
    chk(out_valid == 0 && in_ready == 1, "R1 mid-block reset", 32'({out_valid, in_ready}), 32'h1);
    @(negedge clk); rst_ni = 1;
    rx_n = 0; rx_slot = tx_slot;
    out_ready = 1;
    send_hdr(5);
    send_nibs(0, 0);
    drain;
    chk(total_beats == 5 * SUBS, "R4 beat count", 32'(total_beats), 32'(5 * SUBS));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1;
    @(negedge clk);
    t_basic;
    t_stall;
    t_overlap;
    t_mid_reset;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule